// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts return targets for a branch predictor. It keeps a ring of return addresses of configurable depth. A predicted call pushes the return address. A predicted return pops. After a misprediction, a restore command sets the top-of-stack pointer back to an index the predictor saved earlier, and writes a corrected target into that slot.

The ring never refuses a push. When it is full, a new push overwrites the oldest entry. A pop on an empty ring still moves the pointer, so the top output keeps offering a stale address that can serve as a guess.

The block presents four outputs:
- the address at the top of the stack;
- the top index, for checkpointing;
- an empty flag;
- a full flag.

Occupancy is tracked by a three-state machine, with states `OCC_EMPTY`, `OCC_PARTIAL` and `OCC_FULL`, beside a saturating use counter. Its transitions are:
- push in `OCC_EMPTY` goes to `OCC_PARTIAL`;
- push in `OCC_PARTIAL` with DEPTH-1 entries in use goes to `OCC_FULL`;
- pop in `OCC_PARTIAL` with one entry in use goes to `OCC_EMPTY`;
- pop in `OCC_FULL` goes to `OCC_PARTIAL`;
- every other command keeps the state.

Commands are decoded each cycle into one of four operations: `OP_IDLE`, `OP_PUSH`, `OP_POP` or `OP_RESTORE`.

Top module: `retaddr_stack`

## Requirements
- R1: While reset is asserted and right after it, the block shows top index 0, empty 1, full 0 and top address 0. Every entry is cleared to 0.
- R2: A push alone moves the top index up by one, going from DEPTH-1 to 0. It writes the push address into the new top slot, and that address appears at the top output after the clock edge.
- R3: A pop alone moves the top index down by one, going from 0 to DEPTH-1, and leaves all entries unchanged.
- R4: The top address output always equals the entry at the current top index, with no extra cycle of delay.
- R5: A restore with an index below DEPTH makes that index the top and writes the restore address into that entry. It takes priority over a push or pop in the same cycle.
- R6: A restore leaves the count of used entries unchanged.
- R7: A push and pop in the same cycle, with no valid restore, change nothing: not the index, the entries or the count.
- R8: The used count goes up by one on a push, saturating at DEPTH (the oldest entry is overwritten). It goes down by one on a pop, never below 0, while the index still moves.
- R9: The empty output is 1 exactly when the used count is 0. The full output is 1 exactly when the used count equals DEPTH.
- R10: A restore whose index is DEPTH or larger is dropped. Any push or pop in that cycle acts as though no restore were requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request (predicted call) |
| push_addr_i | input | ADDR_W | Return address to push |
| pop_i | input | 1 | Pop request (predicted return) |
| restore_i | input | 1 | Restore request after misprediction |
| restore_idx_i | input | IDX_W | Saved index to become the top |
| restore_addr_i | input | ADDR_W | Corrected target written at the restored index |
| top_addr_o | output | ADDR_W | Entry at the current top index |
| top_idx_o | output | IDX_W | Current top index, for checkpointing |
| empty_o | output | 1 | No entries in use |
| full_o | output | 1 | DEPTH entries in use |

## Verification
Each command takes effect at the next rising edge, and every output is valid from that edge onward. The index, the flags and the top address all reflect a command one cycle after it is presented, since the top address is read combinationally from the storage at the registered index. The bench applies inputs on the falling edge and advances its behavioural model at the same point. At the next falling edge, before new inputs go out, it compares all four outputs against the model, so each result is checked exactly one cycle after its stimulus.

// File: rtl/ras_pkg.sv
package ras_pkg;

    // Decoded command for one cycle; restore outranks push and pop.
    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_PUSH    = 2'd1,
        OP_POP     = 2'd2,
        OP_RESTORE = 2'd3
    } ras_op_t;

    // Occupancy of the ring.
    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } ras_occ_t;

endpackage

// File: rtl/ras_tos_ptr.sv
module ras_tos_ptr
    import ras_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ras_op_t          op,
    input  logic [IDX_W-1:0] rs_idx,
    output logic [IDX_W-1:0] tos_o,
    output logic [IDX_W-1:0] inc_tos_o
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] tos_q;
    logic [IDX_W-1:0] tos_inc;
    logic [IDX_W-1:0] tos_dec;
    logic [IDX_W-1:0] tos_d;

    always_comb begin
        tos_inc = (tos_q == IDX_LAST) ? '0 : tos_q + 1'b1;
        tos_dec = (tos_q == '0) ? IDX_LAST : tos_q - 1'b1;
        unique case (op)
            OP_PUSH:    tos_d = tos_inc;
            OP_POP:     tos_d = tos_dec;
            OP_RESTORE: tos_d = rs_idx;
            OP_IDLE:    tos_d = tos_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tos_q <= '0;
        else        tos_q <= tos_d;
    end

    assign tos_o     = tos_q;
    assign inc_tos_o = tos_inc;

    // R2
    push_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PUSH && tos_o == IDX_LAST) |=> (tos_o == '0));
    // R3
    pop_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_POP && tos_o == '0) |=> (tos_o == IDX_LAST));
    // R5
    restore_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RESTORE) |=> (tos_o == $past(rs_idx)));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> $stable(tos_o));
endmodule

// File: rtl/ras_occupancy.sv
module ras_occupancy
    import ras_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  ras_op_t op,
    output logic    empty_o,
    output logic    full_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_NEAR = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    ras_occ_t         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next occupancy state and count.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (op == OP_PUSH) begin
                    state_d = OCC_PARTIAL;
                    cnt_d   = CNT_ONE;
                end
            end
            OCC_PARTIAL: begin
                if (op == OP_PUSH) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == CNT_NEAR) state_d = OCC_FULL;
                end else if (op == OP_POP) begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == CNT_ONE) state_d = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (op == OP_POP) begin
                    state_d = OCC_PARTIAL;
                    cnt_d   = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = OCC_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        empty_o = (state_q == OCC_EMPTY);
        full_o  = (state_q == OCC_FULL);
    end

    // R9
    empty_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_EMPTY) == (cnt_q == '0));
    // R9
    full_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_FULL) == (cnt_q == CNT_MAX));
    // R6
    restore_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RESTORE) |=> $stable(cnt_q));
    // R8
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && op == OP_PUSH) |=> full_o);
    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);
endmodule

// File: rtl/ras_entry_file.sv
module ras_entry_file #(
    parameter int DEPTH  = 12,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);
    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                slot_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))     slot_q[g] <= wr_data;
        end
    end

    assign rd_data = (int'(rd_idx) < DEPTH) ? slot_q[rd_idx] : '0;

    // R4
    rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rd_idx) < DEPTH);
endmodule

// File: rtl/retaddr_stack.sv
module retaddr_stack
    import ras_pkg::*;
#(
    parameter int DEPTH  = 12,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    input  logic              restore_i,
    input  logic [IDX_W-1:0]  restore_idx_i,
    input  logic [ADDR_W-1:0] restore_addr_i,
    output logic [ADDR_W-1:0] top_addr_o,
    output logic [IDX_W-1:0]  top_idx_o,
    output logic              empty_o,
    output logic              full_o
);
    ras_op_t           op;
    logic              rs_ok;
    logic [IDX_W-1:0]  inc_tos;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [ADDR_W-1:0] wr_data;

    // Command decode: valid restore first, then a lone push or pop.
    always_comb begin
        rs_ok = restore_i && (int'(restore_idx_i) < DEPTH);
        if (rs_ok)                op = OP_RESTORE;
        else if (push_i && !pop_i) op = OP_PUSH;
        else if (pop_i && !push_i) op = OP_POP;
        else                       op = OP_IDLE;
    end

    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = inc_tos;
        wr_data = push_addr_i;
        unique case (op)
            OP_PUSH: wr_en = 1'b1;
            OP_RESTORE: begin
                wr_en   = 1'b1;
                wr_idx  = restore_idx_i;
                wr_data = restore_addr_i;
            end
            OP_POP, OP_IDLE: wr_en = 1'b0;
        endcase
    end

    ras_tos_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .rs_idx    (restore_idx_i),
        .tos_o     (top_idx_o),
        .inc_tos_o (inc_tos)
    );

    ras_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .empty_o (empty_o),
        .full_o  (full_o)
    );

    ras_entry_file #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (top_idx_o),
        .rd_data (top_addr_o)
    );

    // R2
    push_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !restore_i) |=> (top_addr_o == $past(push_addr_i)));
    // R5
    restore_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && int'(restore_idx_i) < DEPTH) |=> (top_addr_o == $past(restore_addr_i)));
    // R10
    bad_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && int'(restore_idx_i) >= DEPTH && !push_i && !pop_i) |=> $stable(top_idx_o));
    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));
endmodule

// File: tb/tb_retaddr_stack.sv
`timescale 1ns/1ps
module tb_retaddr_stack;
    localparam int DEPTH  = 12;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_i = 1'b0;
    logic [ADDR_W-1:0] push_addr_i = '0;
    logic              pop_i = 1'b0;
    logic              restore_i = 1'b0;
    logic [IDX_W-1:0]  restore_idx_i = '0;
    logic [ADDR_W-1:0] restore_addr_i = '0;
    logic [ADDR_W-1:0] top_addr_o;
    logic [IDX_W-1:0]  top_idx_o;
    logic              empty_o;
    logic              full_o;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Behavioural reference.
    int          m_tos;
    int          m_cnt;
    int unsigned m_mem [DEPTH];

    always #2.5 clk = ~clk;

    retaddr_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .push_addr_i(push_addr_i),
        .pop_i(pop_i), .restore_i(restore_i),
        .restore_idx_i(restore_idx_i), .restore_addr_i(restore_addr_i),
        .top_addr_o(top_addr_o), .top_idx_o(top_idx_o),
        .empty_o(empty_o), .full_o(full_o)
    );

    task automatic cmp(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        cmp({tag, " R4"}, "top_addr", top_addr_o, m_mem[m_tos]);
        cmp({tag, " R2 R3 R5"}, "top_idx", top_idx_o, m_tos);
        cmp({tag, " R9 R8"}, "empty", empty_o, (m_cnt == 0));
        cmp({tag, " R9 R8"}, "full", full_o, (m_cnt == DEPTH));
    endtask

    // Called at a falling edge: check, drive, advance the model, wait one cycle.
    task automatic step(input string tag, input bit ps, input int unsigned pa,
                        input bit pp, input bit rs, input int ri, input int unsigned ra);
        check_all(tag);
        push_i = ps; push_addr_i = pa; pop_i = pp;
        restore_i = rs; restore_idx_i = IDX_W'(ri); restore_addr_i = ra;
        if (rs && ri < DEPTH) begin
            m_tos = ri;
            m_mem[ri] = ra;
        end else if (ps && !pp) begin
            m_tos = (m_tos + 1) % DEPTH;
            m_mem[m_tos] = pa;
            if (m_cnt < DEPTH) m_cnt++;
        end else if (pp && !ps) begin
            m_tos = (m_tos + DEPTH - 1) % DEPTH;
            if (m_cnt > 0) m_cnt--;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= 150000 && !done) begin
                miscompares++;
                $display("FAIL watchdog R1 actual=running expected=finished");
                finish_run();
            end
        end
    end

    initial begin
        m_tos = 0; m_cnt = 0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
        repeat (3) @(negedge clk);
        check_all("R1 in-reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after-reset");

        // R2 R4: a few pushes, then pops back (R3, R8)
        step("R2", 1, 32'h1000_0004, 0, 0, 0, 0);
        step("R2", 1, 32'h1000_0008, 0, 0, 0, 0);
        step("R2", 1, 32'h1000_000C, 0, 0, 0, 0);
        step("R3", 0, 0, 1, 0, 0, 0);
        step("R3", 0, 0, 1, 0, 0, 0);
        step("R3", 0, 0, 1, 0, 0, 0);

        // R8 R9: push past depth, index wraps, oldest overwritten, full saturates
        for (int i = 0; i < DEPTH + 3; i++)
            step("R8 wrap-push", 1, 32'hA000_0000 + 32'(i * 4), 0, 0, 0, 0);

        // R7: push and pop together change nothing
        step("R7", 1, 32'hDEAD_BEEF, 1, 0, 0, 0);
        step("R7", 1, 32'hDEAD_BEEF, 1, 0, 0, 0);

        // R3 R8: pop past empty, index keeps moving through 0 to DEPTH-1
        for (int i = 0; i < DEPTH + 4; i++)
            step("R8 over-pop", 0, 0, 1, 0, 0, 0);

        // R5 R6: restore with and without competing push/pop
        step("R5 R6", 0, 0, 0, 1, 5, 32'hC0DE_0005);
        step("R5 prio-push", 1, 32'h1111_1111, 0, 1, 11, 32'hC0DE_000B);
        step("R5 prio-pop", 0, 0, 1, 1, 0, 32'hC0DE_0000);
        step("R2", 1, 32'h2222_2222, 0, 0, 0, 0);
        step("R5 R6", 1, 32'h3333_3333, 1, 1, 3, 32'hC0DE_0003);

        // R10: out-of-range restore dropped; push/pop still act
        step("R10", 0, 0, 0, 1, 12, 32'hBAD0_000C);
        step("R10 push", 1, 32'h4444_4444, 0, 1, 15, 32'hBAD0_000F);
        step("R10 pop", 0, 0, 1, 1, 13, 32'hBAD0_000D);

        // Mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom;
            step("mix", r[0], $urandom, r[1] & r[2], (r[7:4] == 4'h0), int'(r[11:8]), $urandom);
        end

        push_i = 0; pop_i = 0; restore_i = 0;
        check_all("final");
        done = 1'b1;
        finish_run();
    end
endmodule